// File: doc/BRIEF.md
# Legacy Display I/O Register Block

This block is the bus-side register file of a display controller that imitates the I/O registers of the old monochrome and colour text adapters. It connects to a simple I/O port with a 16-bit address, 8-bit write and read data, and single-cycle read and write strobes. A 16-address window is decoded at either the monochrome base (03B0h) or the colour base (03D0h). Inside the window the block provides:

- an index/data pair that reaches a 32-entry, 8-bit CRTC register array;
- a mode register that can be read back;
- a status register that reports the sync inputs and light-pen information;
- two locations that clear or set a light-pen flag whenever they are accessed.

A setup input enables the whole block. While it is low, every register is held cleared. A second setup input picks the window. The sync levels come from the video timing logic as plain inputs. Read data is registered, so it appears one cycle after the read strobe.

Top module: `legacy_disp_regs`

## Requirements
- R1: While `cfg_enable` is 0, all of these are held at 0: the index register, the mode register, the CRTC array and the light-pen flag. Writes have no effect and every read returns FFh. After re-enabling, all of them read back as 0.
- R2: The window is 03B0h–03BFh when `cfg_color` is 0 and 03D0h–03DFh when it is 1. A read at any address outside the active window returns FFh, and a write there changes nothing.
- R3: Window offsets 0, 2, 4 and 6 all reach the same index register. It stores write-data bits 4:0, and on read it returns them with bits 7:5 set to 0.
- R4: Window offsets 1, 3, 5 and 7 all reach the CRTC array entry selected by the index register, for both read and write.
- R5: Offset 8 is the mode register. It stores write-data bits 6:0 and reads them back, with bit 7 reading 0.
- R6: Offset Ah is the status register. It reads bit 3 = inverted `vsync`, bit 0 = `row_active`, and bits 7:4 = 0, all sampled in the cycle of the read strobe.
- R7: Status bit 2 reads 1 in the colour window and 0 in the monochrome window.
- R8: A read or a write to offset Bh of the colour window clears the light-pen flag, and an access to offset Ch sets it. The change takes effect at the clock edge that ends the access. Accesses to Bh or Ch in the monochrome window do not change the flag. Status bit 1 shows the flag in the colour window and reads 0 in the monochrome window. Reset clears the flag.
- R9: `io_rdata` shows the read result in the cycle after a read strobe and 00h in every cycle that follows a cycle with no read strobe.
- R10: Offsets 9, Bh, Ch, Dh, Eh and Fh read as FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 8 | Write data |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| cfg_enable | input | 1 | Enables the block; 0 holds all registers cleared |
| cfg_color | input | 1 | Window select: 0 = 03Bxh, 1 = 03Dxh |
| vsync | input | 1 | Vertical sync level |
| row_active | input | 1 | High while row data is being clocked out |
| io_rdata | output | 8 | Registered read data |

## Verification
Every read result is due in the first cycle after the strobe, because the design has exactly one register between the port and `io_rdata`. The bench raises the strobe at a falling edge and samples `io_rdata` at the next falling edge. Register updates and light-pen flag changes take effect at the edge that ends the access. The bench therefore updates its model at that point, and only later reads check the new value. Status sync bits are sampled in the strobe cycle, so the bench holds `vsync` and `row_active` steady across each status read.

// File: rtl/ldr_pkg.sv
package ldr_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int IDX_W  = 5;
  localparam int MODE_W = 7;
  localparam int OFF_W  = 4;
  localparam logic [11:0] MONO_PAGE  = 12'h03B;
  localparam logic [11:0] COLOR_PAGE = 12'h03D;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_INDEX,
    ACC_DATA,
    ACC_MODE,
    ACC_STATUS,
    ACC_PEN_CLR,
    ACC_PEN_SET,
    ACC_FILL
  } acc_e;
endpackage

// File: rtl/ldr_decode.sv
module ldr_decode
  import ldr_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int OW = OFF_W
) (
  input  logic [AW-1:0] addr,
  input  logic          enable,
  input  logic          color,
  output acc_e          kind
);
  localparam int PW = AW - OW;
  localparam logic [PW-1:0] MONO_P  = PW'(MONO_PAGE);
  localparam logic [PW-1:0] COLOR_P = PW'(COLOR_PAGE);

  logic          hit;
  logic [OW-1:0] off;

  always_comb begin
    off = addr[OW-1:0];
    hit = enable && (addr[AW-1:OW] == (color ? COLOR_P : MONO_P));
    kind = ACC_NONE;
    if (hit) begin
      if (!off[3]) begin
        kind = off[0] ? ACC_DATA : ACC_INDEX;
      end else begin
        case (off[2:0])
          3'd0:    kind = ACC_MODE;
          3'd2:    kind = ACC_STATUS;
          3'd3:    kind = color ? ACC_PEN_CLR : ACC_FILL;
          3'd4:    kind = color ? ACC_PEN_SET : ACC_FILL;
          default: kind = ACC_FILL;
        endcase
      end
    end
  end
endmodule

// File: rtl/ldr_crtc_array.sv
module ldr_crtc_array #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] addr,
  input  logic [WIDTH-1:0]         wdata,
  output logic [WIDTH-1:0]         rdata
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic             en;
    logic [WIDTH-1:0] d;

    always_comb begin
      en = clear || (we && (addr == AW'(e)));
      d  = clear ? '0 : wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  mem_q[e] <= '0;
      else if (en) mem_q[e] <= d;
    end
  end

  assign rdata = mem_q[addr];
endmodule

// File: rtl/legacy_disp_regs.sv
module legacy_disp_regs
  import ldr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic              cfg_enable,
  input  logic              cfg_color,
  input  logic              vsync,
  input  logic              row_active,
  output logic [DATA_W-1:0] io_rdata
);
  localparam int DEPTH = 1 << IDX_W;

  acc_e              kind;
  logic              clear;
  logic [IDX_W-1:0]  idx_q,   idx_d;
  logic [MODE_W-1:0] mode_q,  mode_d;
  logic              pen_q,   pen_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic [DATA_W-1:0] arr_rd;
  logic              arr_we;

  ldr_decode #(.AW(ADDR_W), .OW(OFF_W)) i_dec (
    .addr   (io_addr),
    .enable (cfg_enable),
    .color  (cfg_color),
    .kind   (kind)
  );

  ldr_crtc_array #(.DEPTH(DEPTH), .WIDTH(DATA_W)) i_arr (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (clear),
    .we    (arr_we),
    .addr  (idx_q),
    .wdata (io_wdata),
    .rdata (arr_rd)
  );

  // next-state logic
  always_comb begin
    clear  = !cfg_enable;
    arr_we = io_wr && (kind == ACC_DATA);

    idx_d = idx_q;
    if (clear)                           idx_d = '0;
    else if (io_wr && kind == ACC_INDEX) idx_d = io_wdata[IDX_W-1:0];

    mode_d = mode_q;
    if (clear)                          mode_d = '0;
    else if (io_wr && kind == ACC_MODE) mode_d = io_wdata[MODE_W-1:0];

    pen_d = pen_q;
    if (clear)                                    pen_d = 1'b0;
    else if ((io_rd || io_wr) && kind == ACC_PEN_CLR) pen_d = 1'b0;
    else if ((io_rd || io_wr) && kind == ACC_PEN_SET) pen_d = 1'b1;

    rdata_d = '0;
    if (io_rd) begin
      case (kind)
        ACC_INDEX:  rdata_d = DATA_W'(idx_q);
        ACC_DATA:   rdata_d = arr_rd;
        ACC_MODE:   rdata_d = DATA_W'(mode_q);
        ACC_STATUS: rdata_d = {4'b0000, ~vsync, cfg_color, pen_q & cfg_color, row_active};
        default:    rdata_d = '1;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      mode_q  <= '0;
      pen_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      idx_q   <= idx_d;
      mode_q  <= mode_d;
      pen_q   <= pen_d;
      rdata_q <= rdata_d;
    end
  end

  assign io_rdata = rdata_q;
endmodule

// File: rtl/ldr_checker.sv
module ldr_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] io_addr,
  input logic        io_rd,
  input logic        cfg_enable,
  input logic        cfg_color,
  input logic [7:0]  io_rdata
);
  logic [15:0] base;
  logic        in_win;

  always_comb begin
    base   = cfg_color ? 16'h03D0 : 16'h03B0;
    in_win = cfg_enable && (io_addr[15:4] == base[15:4]);
  end

  AST_DISABLED_READ_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !cfg_enable) |=> (io_rdata == 8'hFF)); // R1

  AST_OUTSIDE_READ_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !in_win) |=> (io_rdata == 8'hFF)); // R2

  AST_INDEX_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && in_win && !io_addr[3] && !io_addr[0]) |=> (io_rdata[7:5] == 3'b000)); // R3

  AST_MODE_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && in_win && io_addr[3:0] == 4'h8) |=> !io_rdata[7]); // R5

  AST_STATUS_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && in_win && io_addr[3:0] == 4'hA) |=> (io_rdata[7:4] == 4'h0)); // R6

  AST_STATUS_WINDOW_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && in_win && io_addr[3:0] == 4'hA) |=> (io_rdata[2] == $past(cfg_color))); // R7

  AST_MONO_PEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && in_win && !cfg_color && io_addr[3:0] == 4'hA) |=> !io_rdata[1]); // R8

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |=> (io_rdata == 8'h00)); // R9
endmodule

bind legacy_disp_regs ldr_checker i_ldr_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .io_addr    (io_addr),
  .io_rd      (io_rd),
  .cfg_enable (cfg_enable),
  .cfg_color  (cfg_color),
  .io_rdata   (io_rdata)
);

// File: tb/test_legacy_disp_regs.sv
module test_legacy_disp_regs;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] io_addr;
  logic [7:0]  io_wdata;
  logic        io_rd, io_wr;
  logic        cfg_enable, cfg_color, vsync, row_active;
  logic [7:0]  io_rdata;

  int n_chk = 0;
  int n_bad = 0;

  logic [4:0] m_idx;
  logic [6:0] m_mode;
  logic       m_pen;
  logic [7:0] m_arr [32];

  always #2.5 clk = ~clk;

  legacy_disp_regs i_legacy_disp_regs (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_rd(io_rd), .io_wr(io_wr), .cfg_enable(cfg_enable), .cfg_color(cfg_color),
    .vsync(vsync), .row_active(row_active), .io_rdata(io_rdata)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic in_window(input logic [15:0] a);
    logic [15:0] base;
    base = cfg_color ? 16'h03D0 : 16'h03B0;
    return cfg_enable && (a[15:4] == base[15:4]);
  endfunction

  function automatic string req_of(input logic [15:0] a);
    if (!cfg_enable) return "R1";
    if (!in_window(a)) return "R2";
    if (a[3:0] < 4'h8) return a[0] ? "R4" : "R3";
    if (a[3:0] == 4'h8) return "R5";
    if (a[3:0] == 4'hA) return "R6/R7/R8";
    return "R10";
  endfunction

  function automatic logic [7:0] expect_rd(input logic [15:0] a);
    if (!in_window(a)) return 8'hFF;
    if (a[3:0] < 4'h8) return a[0] ? m_arr[m_idx] : {3'b000, m_idx};
    case (a[3:0])
      4'h8:    return {1'b0, m_mode};
      4'hA:    return {4'b0000, ~vsync, cfg_color, m_pen & cfg_color, row_active};
      default: return 8'hFF;
    endcase
  endfunction

  task automatic model_access(input logic [15:0] a, input logic w, input logic [7:0] d);
    if (in_window(a)) begin
      if (w && a[3:0] < 4'h8) begin
        if (a[0]) m_arr[m_idx] = d;
        else      m_idx = d[4:0];
      end
      if (w && a[3:0] == 4'h8) m_mode = d[6:0];
      if (cfg_color && a[3:0] == 4'hB) m_pen = 1'b0;
      if (cfg_color && a[3:0] == 4'hC) m_pen = 1'b1;
    end
  endtask

  task automatic model_clear();
    m_idx = '0; m_mode = '0; m_pen = 1'b0;
    for (int e = 0; e < 32; e++) m_arr[e] = '0;
  endtask

  task automatic do_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    model_access(a, 1'b1, d);
  endtask

  task automatic do_rd(input logic [15:0] a);
    logic [7:0] exp;
    string      req;
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    exp = expect_rd(a);
    req = req_of(a);
    @(negedge clk);
    chk(req, io_rdata, exp);
    io_rd = 1'b0;
    model_access(a, 1'b0, 8'h00);
  endtask

  task automatic sweep_window();
    logic [15:0] base;
    base = cfg_color ? 16'h03D0 : 16'h03B0;
    for (int o = 0; o < 16; o++) do_rd(base + 16'(o));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R9: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] base;
    rst_n = 1'b0; io_addr = '0; io_wdata = '0; io_rd = 1'b0; io_wr = 1'b0;
    cfg_enable = 1'b0; cfg_color = 1'b0; vsync = 1'b0; row_active = 1'b0;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", io_rdata, 8'h00);
    cfg_enable = 1'b1;

    // index/data pair through rotating aliases, both windows (R3, R4)
    for (int s = 0; s < 2; s++) begin
      cfg_color = s[0];
      base = cfg_color ? 16'h03D0 : 16'h03B0;
      sweep_window();
      for (int e = 0; e < 32; e++) begin
        do_wr(base + 16'((e % 4) * 2), 8'(e) | 8'hE0);
        do_wr(base + 16'((e % 4) * 2 + 1), 8'(e * 37 + s * 11));
      end
      for (int e = 0; e < 32; e++) begin
        do_wr(base + 16'(((e + 1) % 4) * 2), 8'(e));
        do_rd(base + 16'(((e + 2) % 4) * 2 + 1));
        do_rd(base + 16'((e % 4) * 2));
      end
      do_wr(base + 16'h0004, 8'hFF);
      do_rd(base + 16'h0006);
      // mode register (R5)
      do_wr(base + 16'h0008, 8'hFF); do_rd(base + 16'h0008);
      do_wr(base + 16'h0008, 8'hAA); do_rd(base + 16'h0008);
      do_wr(base + 16'h0008, 8'h15); do_rd(base + 16'h0008);
      // status sync bits (R6, R7)
      for (int v = 0; v < 4; v++) begin
        vsync = v[1]; row_active = v[0];
        do_rd(base + 16'h000A);
      end
      sweep_window();
    end

    // light-pen flag (R8)
    cfg_color = 1'b1;
    do_rd(16'h03DC); do_rd(16'h03DA);
    do_wr(16'h03DB, 8'h00); do_rd(16'h03DA);
    do_wr(16'h03DC, 8'h00); do_rd(16'h03DA);
    do_rd(16'h03DB); do_rd(16'h03DA);
    do_rd(16'h03DC);
    cfg_color = 1'b0;
    do_rd(16'h03BA); do_rd(16'h03BB); do_wr(16'h03BB, 8'h00);
    cfg_color = 1'b1;
    do_rd(16'h03DA);
    chk("R8", {7'b0, m_pen}, 8'h01);

    // outside the window (R2)
    do_rd(16'h03C4); do_rd(16'h13D4); do_rd(16'h03B8);
    do_wr(16'h03B8, 8'h33); do_wr(16'h03D0 ^ 16'h1000, 8'h07);
    do_rd(16'h03D8); do_rd(16'h03D2);

    // idle read data (R9)
    @(negedge clk);
    chk("R9", io_rdata, 8'h00);

    // disable clears and blocks writes (R1)
    cfg_enable = 1'b0;
    @(negedge clk);
    model_clear();
    do_rd(16'h03DA); do_rd(16'h03D8);
    do_wr(16'h03D0, 8'h05); do_wr(16'h03D8, 8'h7F); do_wr(16'h03DC, 8'h00);
    cfg_enable = 1'b1;
    do_rd(16'h03D8); do_rd(16'h03DA); do_rd(16'h03D0);
    for (int e = 0; e < 32; e++) begin
      do_wr(16'h03D0, 8'(e));
      do_rd(16'h03D1);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule